// File: doc/BRIEF.md
# Burst SRAM address sequencer

This block sits at the front of a synchronous SRAM array and decides, on every rising clock edge, which word the array works on and whether the cycle is a read, a write or a deselect. A new access begins when either of two active-low start strobes is sampled low. One strobe is meant for a processor and the other for a memory controller. A start loads the external address. After that, the two low address bits step through a four-beat burst. An active-low advance input steps the burst and a high advance suspends it.

Three chip enables qualify a start. The processor strobe is masked completely by the first active-low enable. The controller strobe is not masked: if the first enable is inactive, a controller start turns into a deselect. The other two enables, one active high and one active low, are looked at only on a start cycle. A processor start always produces a read. A controller start takes the direction from the decoded write request. A burst runs either in linear order or in XOR-interleaved order, chosen by a mode input that is captured at each load. The output drivers, the byte-write decode and the array itself are outside this block. A read issued with the outputs disabled therefore looks like any other read here and advances the burst in the same way.

Top module: `burst_addr_seq`

## Requirements
- R1: A start sampled with procStrobeN=0 and enLoN=0, with enHi=1 and enLo2N=0, loads addrIn. It then shows cycleValid=1 and isWrite=0 whatever writeReq is. It takes priority over ctrlStrobeN.
- R2: A start sampled with ctrlStrobeN=0, enLoN=0, enHi=1 and enLo2N=0, when R1 does not apply, loads addrIn with cycleValid=1 and isWrite equal to writeReq.
- R3: With enLoN=1, procStrobeN=0 has no effect. If ctrlStrobeN=1 the cycle behaves as a continue or suspend cycle according to advanceN, and cycleValid and isWrite stay unchanged.
- R4: ctrlStrobeN=0 sampled with enLoN=1 gives a deselect: cycleValid=0, isWrite=0, and curAddr is held.
- R5: A start sampled with enHi=0 or enLo2N=1 gives a deselect: cycleValid=0, isWrite=0, and curAddr is held.
- R6: When no start is sampled and advanceN=0, the burst steps one beat.
- R7: When no start is sampled and advanceN=1, curAddr, cycleValid and isWrite are held.
- R8: With orderSel=0 at load (linear), curAddr[1:0] equals the loaded bits plus the beat count, modulo 4. For example, 01 gives 01, 10, 11, 00.
- R9: With orderSel=1 at load (interleaved), curAddr[1:0] equals the loaded bits XOR the beat count. For example, 01 gives 01, 00, 11, 10.
- R10: The fourth step after a load, which is the fifth address of the burst, returns curAddr to the loaded value.
- R11: curAddr bits above bit 1 keep their loaded value until the next load.
- R12: Continue and suspend cycles keep the cycleValid and isWrite values set by the start that began the burst.
- R13: While rstN=0 at a clock edge, the block clears curAddr, cycleValid and isWrite to zero, and the order register to linear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset, active low |
| procStrobeN | input | 1 | Processor start strobe, active low |
| ctrlStrobeN | input | 1 | Controller start strobe, active low |
| advanceN | input | 1 | Burst step enable, active low |
| enLoN | input | 1 | First chip enable, active low, masks the processor strobe |
| enHi | input | 1 | Second chip enable, active high, sampled only on starts |
| enLo2N | input | 1 | Third chip enable, active low, sampled only on starts |
| writeReq | input | 1 | Decoded write request, 1 = write, used by controller starts |
| orderSel | input | 1 | Burst order, 0 = linear, 1 = interleaved |
| addrIn | input | ADDR_W | External address |
| curAddr | output | ADDR_W | Address presented to the array |
| cycleValid | output | 1 | 1 = selected access, 0 = deselect |
| isWrite | output | 1 | Direction tag of the access, 1 = write |

## Verification
Every result is registered once. A start, step, suspend or deselect sampled at one rising edge therefore shows on curAddr, cycleValid and isWrite just after that same edge, and nothing is pending into later cycles. The bench drives its inputs on the falling edge and samples the outputs one time unit after the next rising edge. Each compare is made against a bench model that has been updated with exactly the inputs of that edge. Wrap and order checks run an unbroken series of step cycles from a known load, so beat counts line up with edges one to one.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Per-edge commands from the control decoder to the address datapath.
  typedef struct packed {
    logic load;  // capture external address, clear beat count
    logic step;  // advance the beat count by one
  } seqStrobes_t;

  localparam int BEAT_W = 2;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        procStrobeN,
  input  logic        ctrlStrobeN,
  input  logic        advanceN,
  input  logic        enLoN,
  input  logic        enHi,
  input  logic        enLo2N,
  input  logic        writeReq,
  output seqStrobes_t strobes,
  output logic        cycleValid,
  output logic        isWrite
);
  logic procGo, ctrlGo, startCyc, selOk;

  always_comb begin
    // processor strobe is masked by the first enable
    procGo   = !procStrobeN && !enLoN;
    ctrlGo   = !ctrlStrobeN && !procGo;
    startCyc = procGo || ctrlGo;
    selOk    = !enLoN && enHi && !enLo2N;
    strobes.load = startCyc && selOk;
    strobes.step = !startCyc && !advanceN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleValid <= 1'b0;
      isWrite    <= 1'b0;
    end else if (startCyc) begin
      cycleValid <= selOk;
      isWrite    <= selOk && ctrlGo && writeReq;
    end
  end
endmodule

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] baseAddr;
  logic [BEAT_W-1:0] beatCnt;
  logic              interleaveQ;
  logic [BEAT_W-1:0] lowBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr    <= '0;
      beatCnt     <= '0;
      interleaveQ <= 1'b0;
    end else if (strobes.load) begin
      baseAddr    <= addrIn;
      beatCnt     <= '0;
      interleaveQ <= orderSel;
    end else if (strobes.step) begin
      beatCnt     <= beatCnt + 1'b1;
    end
  end

  always_comb begin
    if (interleaveQ) lowBits = baseAddr[BEAT_W-1:0] ^ beatCnt;
    else             lowBits = baseAddr[BEAT_W-1:0] + beatCnt;
  end

  generate
    if (HI_W > 0) begin : g_upper
      assign curAddr = {baseAddr[ADDR_W-1:BEAT_W], lowBits};
    end else begin : g_lowonly
      assign curAddr = lowBits[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              enLoN,
  input  logic              enHi,
  input  logic              enLo2N,
  input  logic              writeReq,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] curAddr,
  output logic              cycleValid,
  output logic              isWrite
);
  seqStrobes_t strobes;

  burst_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .enLoN(enLoN), .enHi(enHi), .enLo2N(enLo2N),
    .writeReq(writeReq), .strobes(strobes), .cycleValid(cycleValid), .isWrite(isWrite)
  );

  burst_seq_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .orderSel(orderSel),
    .addrIn(addrIn), .curAddr(curAddr)
  );
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              advanceN,
  input logic              enLoN,
  input logic              enHi,
  input logic              enLo2N,
  input logic [ADDR_W-1:0] addrIn,
  input logic [ADDR_W-1:0] curAddr,
  input logic              cycleValid,
  input logic              isWrite
);
  logic idleCyc;
  assign idleCyc = procStrobeN && ctrlStrobeN;

  // R1
  proc_load_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !enLoN && enHi && !enLo2N) |=>
      (cycleValid && !isWrite && curAddr == $past(addrIn)));

  // R4
  ctrl_masked_desel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobeN && enLoN) |=> (!cycleValid && $stable(curAddr)));

  // R3
  proc_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && enLoN && ctrlStrobeN) |=> ($stable(cycleValid) && $stable(isWrite)));

  // R7
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idleCyc && advanceN) |=> ($stable(curAddr) && $stable(cycleValid) && $stable(isWrite)));

  // R6
  step_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idleCyc && !advanceN) |=> (curAddr[1:0] != $past(curAddr[1:0])));

  // R11
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    idleCyc |=> (curAddr[ADDR_W-1:2] == $past(curAddr[ADDR_W-1:2])));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
  .advanceN(advanceN), .enLoN(enLoN), .enHi(enHi), .enLo2N(enLo2N),
  .addrIn(addrIn), .curAddr(curAddr), .cycleValid(cycleValid), .isWrite(isWrite)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic procStrobeN = 1'b1, ctrlStrobeN = 1'b1, advanceN = 1'b1;
  logic enLoN = 1'b0, enHi = 1'b1, enLo2N = 1'b0, writeReq = 1'b0, orderSel = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] curAddr;
  logic cycleValid, isWrite;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [AW-1:0] mBase = '0;
  logic [1:0]    mBeat = '0;
  logic          mInter = 1'b0, mValid = 1'b0, mWrite = 1'b0;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .enLoN(enLoN), .enHi(enHi), .enLo2N(enLo2N),
    .writeReq(writeReq), .orderSel(orderSel), .addrIn(addrIn),
    .curAddr(curAddr), .cycleValid(cycleValid), .isWrite(isWrite)
  );

  function automatic logic [AW-1:0] expAddr();
    logic [1:0] lo;
    lo = mInter ? (mBase[1:0] ^ mBeat) : (mBase[1:0] + mBeat);
    return {mBase[AW-1:2], lo};
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle's inputs at the falling edge, update the model, compare after the rising edge.
  task automatic cyc(input logic pS, input logic cS, input logic adv, input logic e1,
                     input logic e2, input logic e3, input logic wr, input logic ord,
                     input logic [AW-1:0] a, input string forceTag);
    logic procGo, ctrlGo, st, ok;
    string tag, flagTag;
    @(negedge clk);
    procStrobeN = pS; ctrlStrobeN = cS; advanceN = adv; enLoN = e1; enHi = e2;
    enLo2N = e3; writeReq = wr; orderSel = ord; addrIn = a;
    procGo = !pS && !e1;
    ctrlGo = !cS && !procGo;
    st = procGo || ctrlGo;
    ok = !e1 && e2 && !e3;
    if (procGo && ok)             tag = "R1";
    else if (!cS && e1)           tag = "R4";
    else if (st && !ok)           tag = "R5";
    else if (ctrlGo)              tag = "R2";
    else if (!pS && e1)           tag = "R3";
    else if (!adv)                tag = (mBeat == 2'd3) ? "R10" : "R6";
    else                          tag = "R7";
    flagTag = st ? tag : ((!pS && e1) ? "R3" : "R12");
    if (forceTag != "") tag = forceTag;
    if (st) begin
      mValid = ok;
      mWrite = ok && ctrlGo && wr;
      if (ok) begin mBase = a; mBeat = 2'd0; mInter = ord; end
    end else if (!adv) begin
      mBeat = mBeat + 2'd1;
    end
    @(posedge clk); #1;
    check(tag, curAddr, expAddr());
    check({flagTag, " valid"}, {{(AW-1){1'b0}}, cycleValid}, {{(AW-1){1'b0}}, mValid});
    check({flagTag, " write"}, {{(AW-1){1'b0}}, isWrite}, {{(AW-1){1'b0}}, mWrite});
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    logic [AW-1:0] keepHi;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    // R13: reset state
    check("R13 addr", curAddr, '0);
    check("R13 valid", {{(AW-1){1'b0}}, cycleValid}, '0);
    check("R13 write", {{(AW-1){1'b0}}, isWrite}, '0);
    @(negedge clk); rstN = 1'b1;

    // R1: processor start reads even with writeReq high, beats ctrl strobe
    cyc(0, 0, 1, 0, 1, 0, 1, 0, 18'h2A5F1, "R1");
    // R8 / R10: linear 01 -> 10 11 00 01
    cyc(1, 1, 0, 0, 1, 0, 0, 0, 18'h0, "R8");
    cyc(1, 1, 0, 0, 1, 0, 0, 0, 18'h0, "R8");
    cyc(1, 1, 0, 0, 1, 0, 0, 0, 18'h0, "R8");
    cyc(1, 1, 0, 0, 1, 0, 0, 0, 18'h0, "R10");
    check("R11", curAddr, 18'h2A5F1);
    // R7: suspend
    cyc(1, 1, 1, 0, 1, 0, 0, 0, 18'h0, "R7");
    // R2: controller write start, then R9 interleaved and R12 tag kept
    cyc(1, 0, 1, 0, 1, 0, 1, 1, 18'h13C05, "R2");
    cyc(1, 1, 0, 0, 1, 0, 0, 0, 18'h0, "R9");
    cyc(1, 1, 0, 0, 1, 0, 0, 0, 18'h0, "R9");
    cyc(1, 1, 1, 0, 1, 0, 0, 0, 18'h0, "R12");
    cyc(1, 1, 0, 0, 1, 0, 0, 0, 18'h0, "R9");
    cyc(1, 1, 0, 0, 1, 0, 0, 0, 18'h0, "R10");
    check("R10 wrap", curAddr, 18'h13C05);
    check("R12 write kept", {{(AW-1){1'b0}}, isWrite}, 18'h1);
    // R3: processor strobe masked by enLoN, address stream continues
    keepHi = curAddr;
    cyc(0, 1, 1, 1, 1, 0, 0, 0, 18'h3FFFF, "R3");
    check("R3 addr", curAddr, keepHi);
    // R4: controller strobe with enLoN high deselects
    cyc(1, 0, 1, 1, 1, 0, 0, 0, 18'h11111, "R4");
    // R5: enHi low, then enLo2N high
    cyc(1, 0, 1, 0, 1, 0, 0, 1, 18'h00003, "R2");
    cyc(0, 1, 1, 0, 0, 0, 0, 0, 18'h22222, "R5");
    cyc(1, 0, 1, 0, 1, 1, 1, 0, 18'h33333, "R5");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      cyc(($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 3) == 0,
          ($urandom % 6) == 0, ($urandom % 6) != 0, ($urandom % 6) == 0,
          $urandom % 2, $urandom % 2, AW'($urandom), "");
    end
    done = 1;
    finishRun();
  end
endmodule